// File: doc/BRIEF.md
# Keyed GPIO Status Register

The block is a small configuration-space register file that serves four general-purpose pins: two input-only button pins (volume down and volume up) and two bidirectional GPIO pins (GPIO1 and GPIO3). Each pin has a status bit. Under a per-pin mode bit, that status bit either captures the active edge of the pin and holds it until software clears it, or shows the live pin level. A per-pin polarity bit defines which level and which edge count as active. The two GPIO pins also have an output-enable bit and an output-data bit. While a GPIO pin is driven, its status bit reads back the actual pad state.

All control state sits behind a 16-bit key register. The GPIO/status register, and the whole locked range, accepts writes only while the key register holds 4281h. With any other key value, writes to that range are dropped without error. Software reaches the block through a plain register port. The port has a byte address, 32-bit write data with byte enables, a write strobe, and a combinational read-data output. Pin inputs pass through a two-flop synchronizer before they are used.

Top module: `keyed_gpio_regs`

## Requirements
- R1: Offset E0h holds a 16-bit key register. It is written through byte lanes 0 and 1 whatever its current value. It reads back in bits 15:0, and bits 31:16 read 0.
- R2: While the key holds 4281h, a write to offset E8h updates the GPIO/status register. Byte lane 3 writes bits 31:24, lane 2 writes bits 23:16, lane 1 writes the output-data bits, and lane 0 acts on the status bits.
- R3: While the key holds any other value, a write to offset E8h has no effect. The control bits, the data bits, the pin outputs and any set status bit are all left unchanged.
- R4: When a pin's sticky bit is 1, its status bit sets on the pin's active edge and stays set after the pin returns. The active edge is rising when polarity is 0 and falling when polarity is 1. The opposite edge does not set the bit. Status bits are bit 0 for volume-down, bit 1 for volume-up, bit 2 for GPIO1 and bit 3 for GPIO3.
- R5: A set sticky status bit clears only when an unlocked E8h write enables lane 0 with 0 in that bit. Writing 1 there has no effect. If an active edge reaches the bit in the same cycle as a clearing write, the bit stays set.
- R6: When a pin's sticky bit is 0, its status bit reads the synchronized pin level XOR its polarity bit.
- R7: Each pin has a control nibble at bits 16+4p..19+4p, with p = 0 for volume-down, 1 for volume-up, 2 for GPIO1 and 3 for GPIO3. Within the nibble, bit 3 is wake, bit 2 is sticky, bit 1 is polarity and bit 0 is output-enable or latch. For GPIO1 and GPIO3, bits 24 and 28 drive gpio_oe_o[0] and gpio_oe_o[1]. Data bits 8 and 9 drive gpio_o[0] and gpio_o[1]. While a GPIO pin's output-enable bit is set, its status bit shows the synchronized pad state.
- R8: After reset the key, all control bits, output enables, data bits and status bits are 0. Unused bit positions read 0. Reads of any offset other than E0h and E8h return 0.
- R9: All sixteen control bits in bits 31:16 and both data bits store and read back the value written, for any bit pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| vol_dn_i | input | 1 | Volume-down button pin |
| vol_up_i | input | 1 | Volume-up button pin |
| gpio_i | input | 2 | Pad state of GPIO1 (bit 0) and GPIO3 (bit 1) |
| gpio_o | output | 2 | Output data for GPIO1 and GPIO3 |
| gpio_oe_o | output | 2 | Output enables for GPIO1 and GPIO3 |

## Verification
The hardest case to reach is an active edge that arrives in the same cycle as a clearing write. The bench times it by counting the synchronizer and edge-detect registers. It changes the pin on a falling clock edge, lets two rising edges pass, and then issues the clear. That places the clear exactly where the edge would set the flag. Level and sticky behaviour are swept over every pin and both polarities. For sticky mode the sweep covers the active edge, the inactive edge, write-one and write-zero. Locked writes are checked against a flag set beforehand, so a dropped clear is visible at the read port.

// File: rtl/keyed_gpio_pkg.sv
package keyed_gpio_pkg;
  localparam int NPINS     = 4;
  localparam int NGPIO     = 2;
  localparam int GPIO_BASE = 2;   // first bidirectional pin index
  localparam int NIB_W     = 4;
  localparam int CTRL_LSB  = 16;
  localparam int DATA_LSB  = 8;
  localparam int CTRL_W    = NPINS * NIB_W;
  // nibble field positions
  localparam int F_AUX     = 0;   // output-enable or latch
  localparam int F_POL     = 1;
  localparam int F_STICKY  = 2;
  localparam int F_WAKE    = 3;
  localparam logic [7:0]  OFS_KEY  = 8'hE0;
  localparam logic [7:0]  OFS_GPIO = 8'hE8;
  localparam logic [15:0] UNLOCK_KEY = 16'h4281;
endpackage

// File: rtl/kg_sync.sv
module kg_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/kg_key_lock.sv
module kg_key_lock #(
  parameter logic [15:0] KEY_VALUE = 16'h4281
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  be_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] key_o,
  output logic        unlocked_o
);
  logic [15:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_q <= '0;
    else if (we_i) begin
      if (be_i[0]) key_q[7:0]  <= wdata_i[7:0];
      if (be_i[1]) key_q[15:8] <= wdata_i[15:8];
    end
  end

  assign key_o      = key_q;
  assign unlocked_o = (key_q == KEY_VALUE);

  AST_KEY_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(key_q)); // R1
endmodule

// File: rtl/kg_pin_status.sv
module kg_pin_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic prev_i,
  input  logic sticky_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic flag_o,
  output logic level_o
);
  logic act_edge;
  logic flag_q;

  // change on the pin that lands on the active level
  assign act_edge = (sync_i ^ prev_i) & (sync_i ^ pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (!sticky_i) flag_q <= 1'b0;
    else if (act_edge)  flag_q <= 1'b1;  // edge beats a clear
    else if (clr_i)     flag_q <= 1'b0;
  end

  assign flag_o  = flag_q;
  assign level_o = sync_i ^ pol_i;

  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_i && act_edge) |=> flag_q); // R4
  AST_STICKY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_i && flag_q && !clr_i) |=> flag_q); // R5
  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sticky_i && clr_i && !act_edge) |=> !flag_q); // R5
endmodule

// File: rtl/keyed_gpio_regs.sv
module keyed_gpio_regs
  import keyed_gpio_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] KEY_VALUE   = UNLOCK_KEY
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        wr_en_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        vol_dn_i,
  input  logic        vol_up_i,
  input  logic [1:0]  gpio_i,
  output logic [1:0]  gpio_o,
  output logic [1:0]  gpio_oe_o
);
  logic              hit_key, hit_gpio, unlocked, gpio_we;
  logic [15:0]       key_val;
  logic [CTRL_W-1:0] ctrl_q;
  logic [NGPIO-1:0]  data_q;
  logic [NPINS-1:0]  pins, pin_sync, pin_prev, status;

  assign hit_key  = (addr_i[7:2] == OFS_KEY[7:2]);
  assign hit_gpio = (addr_i[7:2] == OFS_GPIO[7:2]);
  assign gpio_we  = wr_en_i && hit_gpio && unlocked;

  kg_key_lock #(.KEY_VALUE(KEY_VALUE)) u_key (
    .clk_i, .rst_ni,
    .we_i      (wr_en_i && hit_key),
    .be_i      (be_i[1:0]),
    .wdata_i   (wdata_i[15:0]),
    .key_o     (key_val),
    .unlocked_o(unlocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      data_q <= '0;
    end else if (gpio_we) begin
      if (be_i[3]) ctrl_q[15:8] <= wdata_i[31:24];
      if (be_i[2]) ctrl_q[7:0]  <= wdata_i[23:16];
      if (be_i[1]) data_q       <= wdata_i[DATA_LSB +: NGPIO];
    end
  end

  assign pins = {gpio_i, vol_up_i, vol_dn_i};

  kg_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .async_i(pins),
    .sync_o (pin_sync),
    .prev_o (pin_prev)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic flag, level, clr, sticky;
    assign sticky = ctrl_q[p*NIB_W + F_STICKY];
    assign clr    = gpio_we && be_i[0] && !wdata_i[p];

    kg_pin_status u_stat (
      .clk_i, .rst_ni,
      .sync_i  (pin_sync[p]),
      .prev_i  (pin_prev[p]),
      .sticky_i(sticky),
      .pol_i   (ctrl_q[p*NIB_W + F_POL]),
      .clr_i   (clr),
      .flag_o  (flag),
      .level_o (level)
    );

    if (p >= GPIO_BASE) begin : g_bidir
      logic oe;
      assign oe        = ctrl_q[p*NIB_W + F_AUX];
      assign status[p] = oe ? pin_sync[p] : (sticky ? flag : level);
      assign gpio_oe_o[p-GPIO_BASE] = oe;
      assign gpio_o[p-GPIO_BASE]    = data_q[p-GPIO_BASE];
    end else begin : g_in
      assign status[p] = sticky ? flag : level;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_key) rdata_o[15:0] = key_val;
    else if (hit_gpio) begin
      rdata_o[CTRL_LSB +: CTRL_W]  = ctrl_q;
      rdata_o[DATA_LSB +: NGPIO]   = data_q;
      rdata_o[NPINS-1:0]           = status;
    end
  end

  AST_LOCKED_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit_gpio && !unlocked) |=> ($stable(ctrl_q) && $stable(data_q))); // R3
  AST_OE_FOLLOWS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpio_we |=> ($stable(gpio_oe_o) && $stable(gpio_o))); // R7
endmodule

// File: tb/keyed_gpio_regs_tb.sv
module keyed_gpio_regs_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic        wr = 0;
  logic [3:0]  be = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        vd = 0, vu = 0;
  logic [1:0]  ext = 0;
  logic [1:0]  gpo, gpoe, pad;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  assign pad = (gpoe & gpo) | (~gpoe & ext);

  keyed_gpio_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .be_i(be),
    .wdata_i(wdata), .rdata_o(rdata), .vol_dn_i(vd), .vol_up_i(vu),
    .gpio_i(pad), .gpio_o(gpo), .gpio_oe_o(gpoe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [7:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; be = 0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_pin(int p, logic v);
    @(negedge clk);
    case (p)
      0: vd = v;
      1: vu = v;
      2: ext[0] = v;
      default: ext[1] = v;
    endcase
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  function automatic logic [31:0] cw(int p, logic st, logic pl, logic oe);
    return (32'(st) << (18 + 4*p)) | (32'(pl) << (17 + 4*p)) | (32'(oe) << (16 + 4*p));
  endfunction

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R8 reset state
    reg_read(8'hE0, rv); chk("R8 key reset", rv, 0);
    reg_read(8'hE8, rv); chk("R8 gpio reset", rv, 0);
    chk("R8 oe reset", {30'b0, gpoe}, 0);
    // R3 locked write ignored
    reg_write(8'hE8, 4'hF, 32'hFFFF_FFFF);
    reg_read(8'hE8, rv); chk("R3 locked write", rv, 0);
    chk("R3 locked oe", {30'b0, gpoe}, 0);
    // R1 key storage and byte lanes
    reg_write(8'hE0, 4'hF, 32'hABCD_1234);
    reg_read(8'hE0, rv); chk("R1 key readback", rv, 32'h0000_1234);
    reg_write(8'hE8, 4'hC, 32'hFFFF_0000);
    reg_read(8'hE8, rv); chk("R3 wrong key", rv, 0);
    reg_write(8'hE0, 4'h1, 32'h0000_0081);
    reg_write(8'hE0, 4'h2, 32'h0000_4200);
    reg_read(8'hE0, rv); chk("R1 key lanes", rv, 32'h0000_4281);
    // R2 R9 control readback sweep
    for (int i = 0; i < 8; i++) begin
      logic [15:0] pat;
      pat = 16'h1 << (2*i) ^ {i[3:0], ~i[3:0], i[3:0], ~i[3:0]};
      reg_write(8'hE8, 4'hC, {pat, 16'h0});
      reg_read(8'hE8, rv); chk("R9 ctrl pattern", {rv[31:16], 16'h0}, {pat, 16'h0});
    end
    reg_write(8'hE8, 4'h4, 32'h0000_0000);
    reg_read(8'hE8, rv); chk("R2 lane2 only", rv[31:16], {rv[31:24], 8'h00});
    reg_write(8'hE8, 4'hE, 32'h0000_0300);
    reg_read(8'hE8, rv); chk("R9 data bits", rv & 32'hFFFF_FFF0, 32'h0000_0300);
    chk("R7 data pins", {30'b0, gpo}, 32'h3);
    reg_write(8'hE8, 4'hE, 32'h0);
    // R8 unused offsets
    foreach (rv[i]) if (i < 4) begin
      logic [31:0] r;
      reg_read(8'hE4 + 8'(i*4 + (i > 0 ? 4 : 0)), r);
      chk("R8 unused offset", r, 0);
    end
    // R6 level sweep
    for (int p = 0; p < 4; p++)
      for (int pl = 0; pl < 2; pl++)
        for (int lv = 0; lv < 2; lv++) begin
          reg_write(8'hE8, 4'hC, cw(p, 0, pl[0], 0));
          set_pin(p, lv[0]); settle();
          reg_read(8'hE8, rv); chk("R6 level", {31'b0, rv[p]}, 32'(lv[0] ^ pl[0]));
          set_pin(p, 0);
        end
    // R4 R5 sticky sweep
    for (int p = 0; p < 4; p++)
      for (int pl = 0; pl < 2; pl++) begin
        logic ia;
        ia = pl[0];
        set_pin(p, ia); settle();
        reg_write(8'hE8, 4'hC, cw(p, 1, ia, 0));
        reg_write(8'hE8, 4'h1, 32'h0);
        reg_read(8'hE8, rv); chk("R5 cleared start", {31'b0, rv[p]}, 0);
        set_pin(p, ~ia); settle();
        reg_read(8'hE8, rv); chk("R4 active edge sets", {31'b0, rv[p]}, 1);
        set_pin(p, ia); settle();
        reg_read(8'hE8, rv); chk("R4 held after return", {31'b0, rv[p]}, 1);
        reg_write(8'hE8, 4'h1, 32'hF);
        reg_read(8'hE8, rv); chk("R5 write one no effect", {31'b0, rv[p]}, 1);
        reg_write(8'hE8, 4'h1, 32'h0);
        reg_read(8'hE8, rv); chk("R5 write zero clears", {31'b0, rv[p]}, 0);
        set_pin(p, ~ia); settle();
        reg_write(8'hE8, 4'h1, 32'h0);
        set_pin(p, ia); settle();
        reg_read(8'hE8, rv); chk("R4 inactive edge ignored", {31'b0, rv[p]}, 0);
        // edge and clear in same cycle
        reg_write(8'hE8, 4'h1, 32'h0);
        set_pin(p, ~ia);
        @(posedge clk); @(posedge clk);
        reg_write(8'hE8, 4'h1, 32'h0);
        settle();
        reg_read(8'hE8, rv); chk("R5 edge beats clear", {31'b0, rv[p]}, 1);
        // R3 locked clear is dropped
        reg_write(8'hE0, 4'h3, 32'h0);
        reg_write(8'hE8, 4'hF, 32'h0);
        reg_read(8'hE8, rv); chk("R3 locked clear", {31'b0, rv[p]}, 1);
        reg_write(8'hE0, 4'h3, 32'h4281);
        set_pin(p, 0);
        reg_write(8'hE8, 4'hC, 32'h0);
      end
    // R7 output readback
    for (int g = 0; g < 2; g++)
      for (int d = 0; d < 2; d++) begin
        ext = 2'b00;
        reg_write(8'hE8, 4'hE, cw(g + 2, 1, 0, 1) | (32'(d) << (8 + g)));
        settle();
        chk("R7 oe pin", {30'b0, gpoe}, 32'(1 << g));
        chk("R7 data pin", {30'b0, gpo}, 32'(d << g));
        reg_read(8'hE8, rv); chk("R7 status shows pad", {31'b0, rv[g+2]}, 32'(d));
      end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule